// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block picks the settings of a fractional-free PLL, namely an input divider, a feedback divider and an output range code, so that the PLL output lands as close as possible to a wanted rate. Given the reference clock rate, the pixel clock rate, the width of the parallel pixel bus and the number of serial lanes, it first works out the wanted PLL rate. It then chooses one of four frequency bands from a fixed table of power-of-two limits. Finally it walks every divider pair in a fixed order, one pair per clock, and keeps the pair with the smallest error.

A start pulse launches a search. The block raises busy until it pulses done together with a fail flag. When a search succeeds in normal mode, the chosen dividers, the range code, the achieved rate and the derived serial clock (half the PLL rate) are stored on the outputs. A verify-only mode answers the same pass/fail question and leaves the stored results as they were. This lets a display mode be screened without disturbing a live setting.

Top module: `pll_div_search`

## Requirements
- R1: At start the block latches target = floor(pixel_rate × data_lines / lanes), truncated to 32 bits; lanes is assumed to be 1 to 4.
- R2: The band limits are 1 000 000 000 Hz shifted right by k for k = 0..4. Let k be the smallest index whose limit the target meets or exceeds. The range code is then k−1, and the band is [limit(k), limit(k−1)).
- R3: If the target is at least 1 000 000 000 Hz or below 62 500 000 Hz, the block pulses done with fail=1 two cycles after the start edge, without scanning.
- R4: Candidates are visited one per clock, with the input divider 0..15 as the outer loop and the feedback divider 0..511 as the inner loop. Each candidate rate is floor(ref × (fbd+1) / ((prd+1) × 2^range)), truncated to 32 bits.
- R5: A candidate is accepted only if its rate is at least the lower band limit and strictly below the upper one.
- R6: An accepted candidate replaces the best only on a strictly smaller absolute error, so the earliest one wins ties. A zero error ends the scan at once. Done comes 2 + (candidates evaluated) cycles after the start edge.
- R7: If no candidate is accepted, fail=1. Otherwise fail=0, and the outputs give the input divider, feedback divider, range code, achieved rate, and the serial clock equal to the achieved rate shifted right by one.
- R8: In verify-only mode, and on any failure, the stored result outputs keep their previous values.
- R9: Busy is high from the cycle after an accepted start until done. Done is a one-cycle pulse with busy low. A start while busy is ignored.
- R10: After a synchronous reset, busy, done, fail and all result outputs are 0, and any search in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| verify_i | input | 1 | Verify-only request, latched at start |
| refclk_hz_i | input | 32 | Reference clock rate in Hz |
| pixclk_hz_i | input | 32 | Pixel clock rate in Hz |
| data_lines_i | input | 6 | Number of parallel input data lines |
| lanes_i | input | 3 | Number of serial lanes (1 to 4) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result of the last search, valid from done |
| prd_o | output | 4 | Stored input divider |
| fbd_o | output | 9 | Stored feedback divider |
| frs_o | output | 2 | Stored output range code |
| pll_hz_o | output | 32 | Stored achieved PLL rate |
| serclk_hz_o | output | 32 | Stored serial clock, half the PLL rate |

## Verification
The search is tried with targets that hit an exact pair early, exactly on the lowest band limit, exactly on the top limit, above the top limit and below the bottom one. This separates early termination from band rejection and probes the inclusive and exclusive band edges. An odd lane count with no exact pair forces a full scan with truncating division. A tiny reference rate leaves the band empty, which separates scan-exhausted failure from band failure. Verify-only runs after a committed result, a start pulse mid-scan and a reset mid-scan show whether the stored results and the scan state are protected, and every run's latency is compared with the number of candidates an exact model visits.

// File: rtl/pll_search_pkg.sv
// Package: shared constants, band limit function and state type for the
// PLL divider search. Assumes the band table is 1 GHz halved per entry.
package pll_search_pkg;
    localparam int unsigned BAND_COUNT = 5;
    localparam logic [31:0] BAND_TOP   = 32'd1_000_000_000;

    // Limit of band entry idx: the top rate halved idx times.
    function automatic logic [31:0] band_limit(input int unsigned idx);
        return BAND_TOP >> idx;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SCAN  = 2'd2
    } srch_state_t;
endpackage

// File: rtl/pll_band_sel.sv
// Band selector: finds the first table limit the target meets or exceeds
// and returns the range code and band edges. Purely combinational.
// Assumes FRS_W can hold BAND_COUNT-2.
module pll_band_sel
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int FRS_W  = 2
) (
    input  logic [RATE_W-1:0] target_i,
    output logic              ok_o,
    output logic [FRS_W-1:0]  frs_o,
    output logic [RATE_W-1:0] lo_o,
    output logic [RATE_W-1:0] hi_o
);
    localparam int IDX_W = $clog2(BAND_COUNT);

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sel;

    // Scan the table from the bottom up so the lowest matching index remains.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = BAND_COUNT - 1; k >= 0; k--) begin
            if (target_i >= RATE_W'(band_limit(k))) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

    // Turn the index into a range code and the two band edges.
    always_comb begin
        ok_o  = hit && (idx != '0);
        sel   = ok_o ? idx - IDX_W'(1) : '0;
        frs_o = FRS_W'(sel);
        hi_o  = RATE_W'(band_limit(int'(sel)));
        lo_o  = RATE_W'(band_limit(int'(sel) + 1));
    end
endmodule

// File: rtl/pll_cand_gen.sv
// Candidate generator: walks (prd, fbd) with prd outer and fbd inner, one
// pair per step, and gives the candidate rate. It keeps ref*(fbd+1) as a
// running sum, so no multiplier is needed. Assumes load precedes steps.
module pll_cand_gen #(
    parameter int RATE_W = 32,
    parameter int PRD_W  = 4,
    parameter int FBD_W  = 9,
    parameter int FRS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [RATE_W-1:0] ref_i,
    input  logic [FRS_W-1:0]  frs_i,
    output logic [PRD_W-1:0]  prd_o,
    output logic [FBD_W-1:0]  fbd_o,
    output logic              last_o,
    output logic [RATE_W-1:0] rate_o
);
    localparam int ACC_W = RATE_W + FBD_W;

    logic [ACC_W-1:0] acc_q;
    logic [PRD_W-1:0] prd_q;
    logic [FBD_W-1:0] fbd_q;
    logic             wrap;
    logic [ACC_W-1:0] shifted;
    logic [ACC_W-1:0] divisor;

    assign wrap   = &fbd_q;
    assign last_o = wrap && (&prd_q);
    assign prd_o  = prd_q;
    assign fbd_o  = fbd_q;

    // Advance the divider pair and the running product ref*(fbd+1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            prd_q <= '0;
            fbd_q <= '0;
        end else if (load_i) begin
            acc_q <= ACC_W'(ref_i);
            prd_q <= '0;
            fbd_q <= '0;
        end else if (step_i) begin
            if (wrap) begin
                fbd_q <= '0;
                prd_q <= prd_q + PRD_W'(1);
                acc_q <= ACC_W'(ref_i);
            end else begin
                fbd_q <= fbd_q + FBD_W'(1);
                acc_q <= acc_q + ACC_W'(ref_i);
            end
        end
    end

    // Candidate rate: shift by the range code, then divide by prd+1.
    always_comb begin
        shifted = acc_q >> frs_i;
        divisor = ACC_W'({1'b0, prd_q}) + ACC_W'(1);
        rate_o  = RATE_W'(shifted / divisor);
    end
endmodule

// File: rtl/pll_div_search.sv
// Top: latches the request, works out the target rate, picks a band, runs
// the candidate scan keeping the closest accepted pair, and commits results
// unless the request was verify-only or failed. Assumes lanes_i in 1..4.
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int PRD_W  = 4,
    parameter int FBD_W  = 9,
    parameter int FRS_W  = 2,
    parameter int PD_W   = 6,
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              verify_i,
    input  logic [31:0]       refclk_hz_i,
    input  logic [31:0]       pixclk_hz_i,
    input  logic [PD_W-1:0]   data_lines_i,
    input  logic [LANE_W-1:0] lanes_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [PRD_W-1:0]  prd_o,
    output logic [FBD_W-1:0]  fbd_o,
    output logic [FRS_W-1:0]  frs_o,
    output logic [31:0]       pll_hz_o,
    output logic [31:0]       serclk_hz_o
);
    localparam int PW = RATE_W + PD_W;

    srch_state_t       state_q;
    logic [RATE_W-1:0] target_q, ref_q;
    logic              verify_q;
    logic              found_q;
    logic [PRD_W-1:0]  best_prd_q;
    logic [FBD_W-1:0]  best_fbd_q;
    logic [RATE_W-1:0] best_rate_q, best_err_q;

    logic [PW-1:0]     prod_w;
    logic [RATE_W-1:0] target_w;
    logic              band_ok;
    logic [FRS_W-1:0]  band_frs;
    logic [RATE_W-1:0] band_lo, band_hi;
    logic [PRD_W-1:0]  cand_prd;
    logic [FBD_W-1:0]  cand_fbd;
    logic              cand_last;
    logic [RATE_W-1:0] cand_rate, cand_err;
    logic              cand_in, better, finish, new_found;
    logic [PRD_W-1:0]  new_prd;
    logic [FBD_W-1:0]  new_fbd;
    logic [RATE_W-1:0] new_rate;
    logic              load, step;

    // Wanted PLL rate from the pixel rate and the bus/lane ratio.
    always_comb begin
        prod_w   = PW'(pixclk_hz_i) * PW'(data_lines_i);
        target_w = RATE_W'(prod_w / PW'(lanes_i));
    end

    pll_band_sel #(.RATE_W(RATE_W), .FRS_W(FRS_W)) band_i (
        .target_i (target_q),
        .ok_o     (band_ok),
        .frs_o    (band_frs),
        .lo_o     (band_lo),
        .hi_o     (band_hi)
    );

    assign load = (state_q == ST_CHECK) && band_ok;
    assign step = (state_q == ST_SCAN) && !finish;

    pll_cand_gen #(.RATE_W(RATE_W), .PRD_W(PRD_W), .FBD_W(FBD_W), .FRS_W(FRS_W)) cand_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .ref_i  (ref_q),
        .frs_i  (band_frs),
        .prd_o  (cand_prd),
        .fbd_o  (cand_fbd),
        .last_o (cand_last),
        .rate_o (cand_rate)
    );

    // Judge the current candidate against the band and the best so far.
    always_comb begin
        cand_in   = (cand_rate >= band_lo) && (cand_rate < band_hi);
        cand_err  = (cand_rate >= target_q) ? cand_rate - target_q : target_q - cand_rate;
        better    = cand_in && (!found_q || (cand_err < best_err_q));
        finish    = (better && (cand_err == '0)) || cand_last;
        new_found = found_q || better;
        new_prd   = better ? cand_prd  : best_prd_q;
        new_fbd   = better ? cand_fbd  : best_fbd_q;
        new_rate  = better ? cand_rate : best_rate_q;
    end

    assign busy_o = (state_q != ST_IDLE);

    // Control sequence, best-candidate tracking and result commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            target_q    <= '0;
            ref_q       <= '0;
            verify_q    <= 1'b0;
            found_q     <= 1'b0;
            best_prd_q  <= '0;
            best_fbd_q  <= '0;
            best_rate_q <= '0;
            best_err_q  <= '0;
            done_o      <= 1'b0;
            fail_o      <= 1'b0;
            prd_o       <= '0;
            fbd_o       <= '0;
            frs_o       <= '0;
            pll_hz_o    <= '0;
            serclk_hz_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        target_q <= target_w;
                        ref_q    <= RATE_W'(refclk_hz_i);
                        verify_q <= verify_i;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    found_q <= 1'b0;
                    if (!band_ok) begin
                        done_o  <= 1'b1;
                        fail_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (better) begin
                        found_q     <= 1'b1;
                        best_prd_q  <= cand_prd;
                        best_fbd_q  <= cand_fbd;
                        best_rate_q <= cand_rate;
                        best_err_q  <= cand_err;
                    end
                    if (finish) begin
                        done_o  <= 1'b1;
                        fail_o  <= !new_found;
                        state_q <= ST_IDLE;
                        if (new_found && !verify_q) begin
                            prd_o       <= new_prd;
                            fbd_o       <= new_fbd;
                            frs_o       <= band_frs;
                            pll_hz_o    <= 32'(new_rate);
                            serclk_hz_o <= 32'(new_rate >> 1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(target_q) && $stable(verify_q))); // R9
    AST_BAND_FAIL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHECK) && !band_ok) |=> (done_o && fail_o)); // R3
    AST_RESULT_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o && !verify_q) |-> ((pll_hz_o >= 32'(band_lo)) && (pll_hz_o < 32'(band_hi)))); // R5
    AST_SERCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o && !verify_q) |-> (serclk_hz_o == (pll_hz_o >> 1))); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (verify_q || fail_o)) |-> ($stable(pll_hz_o) && $stable(prd_o) && $stable(fbd_o) && $stable(frs_o))); // R8
endmodule

// File: tb/pll_div_search_tb_top.sv
`timescale 1ns/1ps
module pll_div_search_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        verify_i = 1'b0;
    logic [31:0] refclk_hz_i = '0;
    logic [31:0] pixclk_hz_i = '0;
    logic [5:0]  data_lines_i = '0;
    logic [2:0]  lanes_i = 3'd1;
    logic        busy_o, done_o, fail_o;
    logic [3:0]  prd_o;
    logic [8:0]  fbd_o;
    logic [1:0]  frs_o;
    logic [31:0] pll_hz_o, serclk_hz_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Expected stored results, kept by the bench itself.
    int unsigned e_prd = 0, e_fbd = 0, e_frs = 0, e_pll = 0;

    always #2.5 clk = ~clk;

    pll_div_search dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_i(verify_i),
        .refclk_hz_i(refclk_hz_i), .pixclk_hz_i(pixclk_hz_i),
        .data_lines_i(data_lines_i), .lanes_i(lanes_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .prd_o(prd_o), .fbd_o(fbd_o), .frs_o(frs_o),
        .pll_hz_o(pll_hz_o), .serclk_hz_o(serclk_hz_o)
    );

    typedef struct packed {
        logic [31:0] refhz;
        logic [31:0] pixhz;
        logic [5:0]  lines;
        logic [2:0]  lanes;
        logic        verify;
        logic        exp_fail;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'd25_000_000, 32'd25_000_000,    6'd24, 3'd4, 1'b0, 1'b0}, // exact early, R6
        '{32'd25_000_000, 32'd200_000_000,   6'd24, 3'd4, 1'b0, 1'b1}, // above top, R3
        '{32'd25_000_000, 32'd10_000_000,    6'd24, 3'd4, 1'b0, 1'b1}, // below bottom, R3
        '{32'd25_000_000, 32'd1_000_000_000, 6'd4,  3'd4, 1'b0, 1'b1}, // equal top, R2
        '{32'd25_000_000, 32'd62_500_000,    6'd4,  3'd4, 1'b0, 1'b0}, // equal bottom, R2
        '{32'd27_000_000, 32'd33_333_333,    6'd24, 3'd3, 1'b0, 1'b0}, // full scan, R1 R4
        '{32'd1000,       32'd25_000_000,    6'd24, 3'd4, 1'b0, 1'b1}, // empty band, R7
        '{32'd25_000_000, 32'd25_000_000,    6'd24, 3'd4, 1'b1, 1'b0}, // verify pass, R8
        '{32'd25_000_000, 32'd200_000_000,   6'd24, 3'd4, 1'b1, 1'b1}  // verify fail, R8
    };

    task automatic chk(input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Exact model of the search, written from the requirements.
    task automatic model(input int unsigned refhz, input int unsigned pixhz,
                         input int unsigned lines, input int unsigned lanes,
                         output bit ok, output int unsigned prd, output int unsigned fbd,
                         output int unsigned frs, output int unsigned rate,
                         output int unsigned evals);
        int unsigned target, idx, lo, hi, best_err;
        bit stop;
        target = 32'((64'(pixhz) * 64'(lines)) / 64'(lanes));
        idx = 5;
        for (int k = 0; k < 5; k++)
            if (idx == 5 && target >= (32'd1_000_000_000 >> k)) idx = k;
        ok = 0; prd = 0; fbd = 0; frs = 0; rate = 0; evals = 0;
        if (idx == 0 || idx == 5) return;
        frs = idx - 1;
        hi = 32'd1_000_000_000 >> frs;
        lo = 32'd1_000_000_000 >> idx;
        best_err = 0;
        stop = 0;
        for (int p = 0; p < 16; p++) begin
            for (int f = 0; f < 512; f++) begin
                if (!stop) begin
                    int unsigned r, e;
                    evals++;
                    r = 32'((64'(refhz) * 64'(f + 1)) / (64'(p + 1) << frs));
                    if (r >= lo && r < hi) begin
                        e = (r >= target) ? r - target : target - r;
                        if (!ok || e < best_err) begin
                            ok = 1; best_err = e; prd = p; fbd = f; rate = r;
                            if (e == 0) stop = 1;
                        end
                    end
                end
            end
        end
    endtask

    // Issue one request and compare status, latency and stored results.
    task automatic run_vec(input vec_t v, input int num);
        bit ok;
        int unsigned m_prd, m_fbd, m_frs, m_rate, m_evals;
        int lat;
        model(v.refhz, v.pixhz, v.lines, v.lanes, ok, m_prd, m_fbd, m_frs, m_rate, m_evals);
        @(negedge clk);
        refclk_hz_i = v.refhz; pixclk_hz_i = v.pixhz;
        data_lines_i = v.lines; lanes_i = v.lanes; verify_i = v.verify;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        chk($sformatf("R9 busy after start v%0d", num), busy_o, 1);
        while (!done_o) begin
            @(negedge clk);
            lat++;
        end
        if (ok && !v.verify) begin
            e_prd = m_prd; e_fbd = m_fbd; e_frs = m_frs; e_pll = m_rate;
        end
        chk($sformatf("R3 R7 fail table v%0d", num), fail_o, v.exp_fail);
        chk($sformatf("R7 fail model v%0d", num), fail_o, !ok);
        chk($sformatf("R4 R6 latency v%0d", num), lat, 2 + m_evals);
        chk($sformatf("R1 R2 R7 R8 prd v%0d", num), prd_o, e_prd);
        chk($sformatf("R4 R6 R8 fbd v%0d", num), fbd_o, e_fbd);
        chk($sformatf("R2 R8 frs v%0d", num), frs_o, e_frs);
        chk($sformatf("R5 R7 R8 pll v%0d", num), pll_hz_o, e_pll);
        chk($sformatf("R7 serclk v%0d", num), serclk_hz_o, e_pll / 2);
        chk($sformatf("R9 not busy at done v%0d", num), busy_o, 0);
        @(negedge clk);
        chk($sformatf("R9 done one cycle v%0d", num), done_o, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 busy after reset", busy_o, 0);
        chk("R10 done after reset", done_o, 0);
        chk("R10 fail after reset", fail_o, 0);
        chk("R10 pll after reset", pll_hz_o, 0);
        chk("R10 prd after reset", prd_o, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R9: a start while busy is ignored; the first request completes.
        begin
            int lat;
            @(negedge clk);
            refclk_hz_i = 32'd25_000_000; pixclk_hz_i = 32'd62_500_000;
            data_lines_i = 6'd4; lanes_i = 3'd4; verify_i = 1'b0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            lat = 1;
            repeat (4) begin @(negedge clk); lat++; end
            pixclk_hz_i = 32'd200_000_000; data_lines_i = 6'd24; verify_i = 1'b1;
            start_i = 1'b1;
            @(negedge clk); lat++;
            start_i = 1'b0;
            while (!done_o) begin @(negedge clk); lat++; end
            chk("R9 start while busy fail", fail_o, 0);
            chk("R9 start while busy latency", lat, 2 + 20);
            chk("R9 start while busy pll", pll_hz_o, 62_500_000);
            chk("R9 start while busy fbd", fbd_o, 19);
            @(negedge clk);
            chk("R9 no second search", busy_o, 0);
        end

        // R10: reset in the middle of a long scan.
        @(negedge clk);
        refclk_hz_i = 32'd1000; pixclk_hz_i = 32'd25_000_000;
        data_lines_i = 6'd24; lanes_i = 3'd4; verify_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 busy after mid-scan reset", busy_o, 0);
        chk("R10 pll after mid-scan reset", pll_hz_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 stays idle", busy_o, 0);
        chk("R10 no done after reset", done_o, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule